// File: doc/BRIEF.md
# Multiprocessor UART Receiver

This block is the receive half of an asynchronous serial port. It samples the serial line at sixteen times the bit rate and assembles frames made of a start bit, eight data bits sent least significant bit first, and an optional extra bit, followed by a stop bit. The extra bit is either a parity bit or, in 9-bit format, a ninth data bit. Each accepted frame is moved into a receive buffer, and a buffer-full flag tells the host that a byte is waiting. A status word reports parity, framing and overrun errors, a summary error, a line break and the last ninth bit. Reading the status clears its error flags.

For multidrop links, the host can arm an attention mode. While it is armed, the receiver drops every frame that is not an address frame. An address frame is a 9-bit frame whose ninth bit is 1. When one arrives, the receiver accepts it and disarms attention mode by itself. The host reads the block through two one-cycle strobes, one for the buffer and one for the status. The bit-rate tick comes from a divider outside the block.

Top module: `mp_uart_rx`

## Requirements
- R1: One bit time is 16 baud ticks. A start bit is accepted only if the line is still low at the 8th tick after the first low sample. Each later bit is sampled 16 ticks after the previous sample. Data arrives least significant bit first.
- R2: When a frame is accepted, its data byte appears on `rx_data` and `buf_full` sets. A one-cycle `rd_buf` pulse clears `buf_full`.
- R3: With parity enabled and 8-bit format, one bit follows the data. `cfg_par_sel` chooses the expected value of that bit: 2'b00 makes the total count of ones odd, 2'b01 makes it even, 2'b10 expects 0 and 2'b11 expects 1. `st_pe` sets on a mismatch.
- R4: In 9-bit format (`cfg_nine`=1), the bit after the data is the ninth data bit and is copied to `st_b9`. There is no parity bit, and `cfg_par_en` and `cfg_par_sel` have no effect.
- R5: `st_fe` sets when the stop bit is sampled low.
- R6: `st_ovr` sets when a frame is accepted while `buf_full` is still 1. The new byte replaces the old one.
- R7: A one-cycle `rd_stat` pulse clears `st_pe`, `st_fe` and `st_ovr`. Each of these flags stays set until such a read.
- R8: `st_err` is 1 exactly when at least one of `st_pe`, `st_fe` or `st_ovr` is 1.
- R9: `st_brk` sets when the line stays low for 10 bit times (160 ticks) after a low stop-bit sample. A shorter low period leaves `st_brk` clear.
- R10: A status read clears `st_brk` at once if the line is high. If the line is still low at that read, `st_brk` stays set and clears on its own when the line returns high. If there is no read, `st_brk` stays set even after the line returns high.
- R11: An `atn_arm` pulse sets `atn_active`. While `atn_active` is set, the block discards every frame that is not an address frame: `rx_data`, `buf_full` and all status flags stay unchanged. In 8-bit format no frame counts as an address frame. Accepting an address frame clears `atn_active`.
- R12: After reset, `rx_data` is 0 and every flag output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, idle high |
| tick16 | input | 1 | Baud tick at 16 times the bit rate, one clock wide |
| cfg_nine | input | 1 | Selects 9-bit data format |
| cfg_par_en | input | 1 | Enables the parity bit in 8-bit format |
| cfg_par_sel | input | 2 | Parity type: 00 odd, 01 even, 10 fixed 0, 11 fixed 1 |
| atn_arm | input | 1 | Pulse that arms attention mode |
| rd_buf | input | 1 | Pulse marking a read of the receive buffer |
| rd_stat | input | 1 | Pulse marking a read of the status |
| rx_data | output | 8 | Last accepted data byte |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| st_pe | output | 1 | Parity error |
| st_fe | output | 1 | Framing error |
| st_ovr | output | 1 | Overrun error |
| st_err | output | 1 | Any of the three errors |
| st_brk | output | 1 | Line break detected |
| st_b9 | output | 1 | Ninth bit of the last 9-bit frame |
| atn_active | output | 1 | Attention mode armed |

## Verification
If the sampling counter is off, the error shows up in the very next frame: `rx_data` holds a shifted byte, or the parity or framing flag is wrong, one bit time after the stop bit. If the flag state is wrong, it shows at the first status read, or after the line returns high during a break. A break flag that clears too early, or never clears, is visible within a few clocks of the line going high. If the attention state goes wrong, a non-address frame appears in the buffer, or a later data frame is dropped, one frame later.

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OVS        = 16,
  parameter int BREAK_BITS = 10,
  parameter int SYNC       = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       tick16,
  input  logic       cfg_nine,
  input  logic       cfg_par_en,
  input  logic [1:0] cfg_par_sel,
  input  logic       atn_arm,
  input  logic       rd_buf,
  input  logic       rd_stat,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       st_pe,
  output logic       st_fe,
  output logic       st_ovr,
  output logic       st_err,
  output logic       st_brk,
  output logic       st_b9,
  output logic       atn_active
);

  localparam int CW        = $clog2(OVS);
  localparam int HALF      = OVS / 2;
  localparam int BRK_TICKS = BREAK_BITS * OVS;
  localparam int BW        = $clog2(BRK_TICKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_EXTRA, S_STOP, S_BRK, S_HOLD} rx_state_e;

  rx_state_e       st;
  logic [SYNC-1:0] sync_q;
  logic            rxd_s;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bcnt;
  logic [2:0]      idx;
  logic [7:0]      shreg;
  logic            ex_bit;
  logic            brk_pend;

  assign rxd_s = sync_q[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC-2:0], rxd};

  wire mid       = tick16 && (cnt == CW'(OVS - 1));
  wire stop_at   = (st == S_STOP) && mid;
  wire brk_hit   = (st == S_BRK) && tick16 && !rxd_s && (bcnt == BW'(BRK_TICKS - 1));
  wire f_addr    = cfg_nine && ex_bit;
  wire discard   = atn_active && !f_addr;
  wire f_load    = stop_at && !discard;
  wire use_extra = cfg_nine || cfg_par_en;

  logic par_exp;
  always_comb
    case (cfg_par_sel)
      2'b00:   par_exp = ~^shreg;
      2'b01:   par_exp = ^shreg;
      2'b10:   par_exp = 1'b0;
      default: par_exp = 1'b1;
    endcase

  wire pe_hit = !cfg_nine && cfg_par_en && (ex_bit != par_exp);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bcnt   <= '0;
      idx    <= '0;
      shreg  <= '0;
      ex_bit <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (tick16 && !rxd_s) begin
            st  <= S_START;
            cnt <= CW'(1);
          end
        S_START:
          if (tick16) begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              idx <= '0;
              st  <= rxd_s ? S_IDLE : S_DATA;
            end else cnt <= cnt + 1'b1;
          end
        S_DATA:
          if (mid) begin
            cnt   <= '0;
            shreg <= {rxd_s, shreg[7:1]};
            idx   <= idx + 1'b1;
            if (idx == 3'd7) st <= use_extra ? S_EXTRA : S_STOP;
          end else if (tick16) cnt <= cnt + 1'b1;
        S_EXTRA:
          if (mid) begin
            cnt    <= '0;
            ex_bit <= rxd_s;
            st     <= S_STOP;
          end else if (tick16) cnt <= cnt + 1'b1;
        S_STOP:
          if (mid) begin
            cnt  <= '0;
            bcnt <= '0;
            st   <= rxd_s ? S_IDLE : S_BRK;
          end else if (tick16) cnt <= cnt + 1'b1;
        S_BRK:
          if (tick16) begin
            if (rxd_s)        st <= S_IDLE;
            else if (brk_hit) st <= S_HOLD;
            else              bcnt <= bcnt + 1'b1;
          end
        default:
          if (rxd_s) st <= S_IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data    <= '0;
      buf_full   <= 1'b0;
      st_pe      <= 1'b0;
      st_fe      <= 1'b0;
      st_ovr     <= 1'b0;
      st_b9      <= 1'b0;
      atn_active <= 1'b0;
    end else begin
      buf_full   <= f_load | (buf_full & ~rd_buf);
      st_pe      <= (st_pe  & ~rd_stat) | (f_load & pe_hit);
      st_fe      <= (st_fe  & ~rd_stat) | (f_load & ~rxd_s);
      st_ovr     <= (st_ovr & ~rd_stat) | (f_load & buf_full & ~rd_buf);
      atn_active <= atn_arm | (atn_active & ~(f_load & f_addr));
      if (f_load) begin
        rx_data <= shreg;
        if (cfg_nine) st_b9 <= ex_bit;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_brk   <= 1'b0;
      brk_pend <= 1'b0;
    end else if (brk_hit) begin
      st_brk   <= 1'b1;
      brk_pend <= 1'b0;
    end else if (st_brk && rd_stat && rxd_s) begin
      st_brk   <= 1'b0;
      brk_pend <= 1'b0;
    end else if (st_brk && rd_stat) begin
      brk_pend <= 1'b1;
    end else if (brk_pend && rxd_s) begin
      st_brk   <= 1'b0;
      brk_pend <= 1'b0;
    end

  assign st_err = st_pe | st_fe | st_ovr;

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(buf_full) |-> $past(rd_buf)); // R2
  AST_PE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pe) |-> $past(!cfg_nine && cfg_par_en)); // R3
  AST_NINE_NOPAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_nine && !st_pe) |=> !st_pe); // R4
  AST_FE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_fe) |-> $past(st == S_STOP && !rxd_s)); // R5
  AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ovr) |-> $past(buf_full)); // R6
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_fe && !rd_stat) |=> st_fe); // R7
  AST_BRK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_brk) |-> $past(st == S_BRK && !rxd_s)); // R9
  AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st_brk && !rxd_s) |=> st_brk); // R10
  AST_ATN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(atn_active) |-> $past(stop_at && f_addr)); // R11
  AST_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_at && discard) |=> $stable(rx_data)); // R11

endmodule

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
  localparam int TDIV = 4;
  localparam int BT   = 16 * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick16;
  logic       cfg_nine = 1'b0, cfg_par_en = 1'b0;
  logic [1:0] cfg_par_sel = 2'b00;
  logic       atn_arm = 1'b0, rd_buf = 1'b0, rd_stat = 1'b0;
  logic [7:0] rx_data;
  logic       buf_full, st_pe, st_fe, st_ovr, st_err, st_brk, st_b9, atn_active;
  logic [1:0] tdiv = '0;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick16 = (tdiv == 2'd3);

  mp_uart_rx i_mp_uart_rx (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16),
    .cfg_nine(cfg_nine), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .atn_arm(atn_arm), .rd_buf(rd_buf), .rd_stat(rd_stat),
    .rx_data(rx_data), .buf_full(buf_full), .st_pe(st_pe), .st_fe(st_fe),
    .st_ovr(st_ovr), .st_err(st_err), .st_brk(st_brk), .st_b9(st_b9),
    .atn_active(atn_active)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog act=%0d exp<=150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic hold_bits(input logic v, input int n);
    rxd = v;
    repeat (n * BT) @(negedge clk);
  endtask

  task automatic send_body(input logic [7:0] d, input logic has_ex, input logic ex);
    hold_bits(1'b0, 1);
    for (int i = 0; i < 8; i++) hold_bits(d[i], 1);
    if (has_ex) hold_bits(ex, 1);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic has_ex, input logic ex, input logic stop);
    send_body(d, has_ex, ex);
    hold_bits(stop, 1);
    hold_bits(1'b1, 2);
  endtask

  task automatic pulse_buf();
    rd_buf = 1'b1; @(negedge clk); rd_buf = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_stat();
    rd_stat = 1'b1; @(negedge clk); rd_stat = 1'b0; @(negedge clk);
  endtask

  task automatic clean();
    pulse_buf();
    pulse_stat();
  endtask

  task automatic t_reset();
    check("R12 rx_data", rx_data, 8'h00);
    check("R12 flags", {buf_full, st_pe, st_fe, st_ovr, st_err, st_brk, st_b9, atn_active}, 8'h00);
  endtask

  task automatic t_plain();
    cfg_nine = 0; cfg_par_en = 0;
    send_frame(8'hA5, 0, 0, 1);
    check("R1 data A5", rx_data, 8'hA5);
    check("R2 full set", buf_full, 1'b1);
    check("R5 no fe", st_fe, 1'b0);
    pulse_buf();
    check("R2 full clr", buf_full, 1'b0);
    send_frame(8'h01, 0, 0, 1);
    check("R1 lsb first", rx_data, 8'h01);
    clean();
  endtask

  task automatic t_parity();
    cfg_nine = 0; cfg_par_en = 1; cfg_par_sel = 2'b01;
    send_frame(8'h3C, 1, ^8'h3C, 1);
    check("R3 even ok", st_pe, 1'b0);
    check("R3 even data", rx_data, 8'h3C);
    clean();
    cfg_par_sel = 2'b00;
    send_frame(8'h07, 1, ^8'h07, 1);
    check("R3 odd bad", st_pe, 1'b1);
    check("R8 err on pe", st_err, 1'b1);
    pulse_buf();
    check("R7 pe held", st_pe, 1'b1);
    pulse_stat();
    check("R7 pe cleared", st_pe, 1'b0);
    check("R8 err cleared", st_err, 1'b0);
    cfg_par_sel = 2'b10;
    send_frame(8'h55, 1, 1'b1, 1);
    check("R3 fixed0 bad", st_pe, 1'b1);
    clean();
    cfg_par_sel = 2'b11;
    send_frame(8'h55, 1, 1'b1, 1);
    check("R3 fixed1 ok", st_pe, 1'b0);
    clean();
  endtask

  task automatic t_nine();
    cfg_nine = 1; cfg_par_en = 1; cfg_par_sel = 2'b10;
    send_frame(8'h5A, 1, 1'b1, 1);
    check("R4 data", rx_data, 8'h5A);
    check("R4 b9 one", st_b9, 1'b1);
    check("R4 no pe", st_pe, 1'b0);
    clean();
    cfg_par_sel = 2'b11;
    send_frame(8'hC3, 1, 1'b0, 1);
    check("R4 b9 zero", st_b9, 1'b0);
    check("R4 no pe 2", st_pe, 1'b0);
    clean();
    cfg_par_en = 0;
  endtask

  task automatic t_frame_ovr();
    cfg_nine = 0; cfg_par_en = 0;
    send_frame(8'h99, 0, 0, 0);
    check("R5 fe", st_fe, 1'b1);
    check("R8 err fe", st_err, 1'b1);
    check("R9 no brk short", st_brk, 1'b0);
    clean();
    check("R7 fe cleared", st_fe, 1'b0);
    send_frame(8'h11, 0, 0, 1);
    send_frame(8'h22, 0, 0, 1);
    check("R6 ovr", st_ovr, 1'b1);
    check("R6 new data", rx_data, 8'h22);
    check("R8 err ovr", st_err, 1'b1);
    clean();
    check("R7 ovr cleared", st_ovr, 1'b0);
  endtask

  task automatic t_break();
    cfg_nine = 0; cfg_par_en = 0;
    send_body(8'h00, 0, 0);
    hold_bits(1'b0, 6);
    hold_bits(1'b1, 2);
    check("R9 short low no brk", st_brk, 1'b0);
    clean();
    send_body(8'h00, 0, 0);
    hold_bits(1'b0, 12);
    check("R9 brk set", st_brk, 1'b1);
    pulse_stat();
    check("R10 brk held low", st_brk, 1'b1);
    check("R7 fe cleared brk", st_fe, 1'b0);
    hold_bits(1'b0, 1);
    check("R10 still low", st_brk, 1'b1);
    rxd = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 auto clear", st_brk, 1'b0);
    hold_bits(1'b1, 2);
    clean();
    send_body(8'h00, 0, 0);
    hold_bits(1'b0, 12);
    hold_bits(1'b1, 2);
    check("R10 no read keeps", st_brk, 1'b1);
    pulse_stat();
    check("R10 read high clears", st_brk, 1'b0);
    clean();
  endtask

  task automatic t_atn();
    logic [7:0] prev;
    cfg_nine = 1; cfg_par_en = 0;
    send_frame(8'h44, 1, 1'b0, 1);
    clean();
    prev = rx_data;
    atn_arm = 1'b1; @(negedge clk); atn_arm = 1'b0; @(negedge clk);
    check("R11 armed", atn_active, 1'b1);
    send_frame(8'h11, 1, 1'b0, 1);
    check("R11 drop full", buf_full, 1'b0);
    check("R11 drop data", rx_data, prev);
    check("R11 still armed", atn_active, 1'b1);
    send_frame(8'h33, 1, 1'b0, 0);
    check("R11 drop no fe", st_fe, 1'b0);
    send_frame(8'h22, 1, 1'b1, 1);
    check("R11 addr full", buf_full, 1'b1);
    check("R11 addr data", rx_data, 8'h22);
    check("R11 disarmed", atn_active, 1'b0);
    check("R4 addr b9", st_b9, 1'b1);
    clean();
    send_frame(8'h66, 1, 1'b0, 1);
    check("R11 data after addr", rx_data, 8'h66);
    clean();
    cfg_nine = 0;
    atn_arm = 1'b1; @(negedge clk); atn_arm = 1'b0; @(negedge clk);
    send_frame(8'h77, 0, 0, 1);
    check("R11 8bit dropped", buf_full, 1'b0);
    check("R11 8bit armed", atn_active, 1'b1);
  endtask

  task automatic t_glitch();
    rst_n = 1'b0; repeat (3) @(negedge clk); rst_n = 1'b1; @(negedge clk);
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    hold_bits(1'b1, 12);
    check("R1 glitch rejected", buf_full, 1'b0);
    send_frame(8'hE7, 0, 0, 1);
    check("R1 after glitch", rx_data, 8'hE7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain();
    t_parity();
    t_nine();
    t_frame_ovr();
    t_break();
    t_atn();
    t_glitch();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule